// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of eight DMA channels owns the memory bus. Each channel raises a request line. The arbiter issues a one-hot grant to a single channel. The data mover that performs the transfers pulses a strobe once for every byte it moves on behalf of that channel.

Three ranking policies are available: fixed ranking, rotation after each byte, and rotation after each burst. The arbiter caps the number of bytes in one burst. It also holds the bus idle for a programmable number of clocks after every burst, so the processor keeps a guaranteed share of bus time.

A two-bit DMA level is compared with the current processor level. When the processor level is above the DMA level, no new burst starts and any running burst is cut off. When DMA work is permitted and pending, an indication tells the interrupt logic that a simultaneous interrupt request must wait.

Top module: `dma_chan_arbiter`

## Requirements
- R1: In fixed ranking, a higher channel number always beats a lower one. Channel 0 is granted only when no other channel requests. Example: requests 8'h18 give grant 8'h10, and requests 8'h81 give grant 8'h80.
- R2: The policy field selects the ranking. `pol_mode` = 2'b00 or 2'b01 is fixed ranking. 2'b10 rotates after every byte. 2'b11 rotates only when a burst ends.
- R3: Rotation step k ranks the channels from channel 7−k (highest) downward, wrapping past channel 0 to channel 7. After reset the step is 0. In rotating policies the step advances by one per byte (2'b10) or per burst end (2'b11), and it wraps from 7 to 0. Fixed ranking always uses step 0.
- R4: In the two per-byte policies the ranking is re-evaluated on each `byte_done`. If a requester ranks above the granted channel under the ranking that applies after that byte, it takes over. No takeover happens between bytes. In per-burst rotation, no takeover happens inside a burst.
- R5: A change of grant from one channel to another inserts exactly one clock with `grant` all zero while `burst_act` stays 1. Consecutive bytes on the same channel keep `grant` unchanged with no gap.
- R6: `burst_code` 0..7 sets the byte cap to 1, 2, 3, 4, 8, 16, 32 or 64. The burst ends on the `byte_done` that reaches the cap. Bytes moved before a takeover count toward the same burst.
- R7: `gap_code` 0..7 sets the idle gap to 12, 16, 24, 32, 64, 128, 256 or 512 clocks. After a burst ends, `grant` and `burst_act` stay 0 for exactly that many clocks while a permitted request is held.
- R8: A burst ends, and the gap starts, on the clock after the granted channel drops its request or after the level gate closes.
- R9: A burst may start only while `cpu_lvl` <= `dma_lvl`. DMA level 3 allows transfers at any processor level, and DMA level 0 allows them only at processor level 0.
- R10: `dma_wins` is 1 exactly when `irq_pend` is 1, some request is set, and the level gate is open.
- R11: After reset, `grant` = 0, `burst_act` = 0 and the gap timer is clear. From idle, the grant appears one clock after a permitted request is seen. `grant` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_CH | Per-channel transfer requests |
| byte_done | input | 1 | One pulse per byte moved for the granted channel |
| pol_mode | input | 2 | Ranking policy select |
| burst_code | input | 3 | Coded maximum bytes per burst |
| gap_code | input | 3 | Coded minimum idle clocks between bursts |
| cpu_lvl | input | 2 | Current processor priority level |
| dma_lvl | input | 2 | Level at which DMA may run |
| irq_pend | input | 1 | An interrupt request is pending |
| grant | output | NUM_CH | One-hot channel grant |
| burst_act | output | 1 | DMA owns the bus, including the dead clock of a switch |
| dma_wins | output | 1 | Pending DMA work takes precedence over the interrupt |

## Verification
The bench targets the points where the grant changes hands. A design that lets a higher channel take over between bytes, or that skips the dead clock, shows the new grant one cycle early. A design that rotates on the wrong event, or that reads the pre-byte ranking for a takeover, grants channel 6 where channel 7 is expected in the alternating rotation sequence. A design that lets per-burst rotation take over inside a burst keeps granting channel 5 too soon.

Idle gaps are measured in clocks for several codes, including the 512-clock maximum and gaps that follow a dropped request or a closed level gate. Any off-by-one in the timer or the code decode changes the measured count.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BURST = 2'd1,
      ST_DEAD  = 2'd2,
      ST_GAP   = 2'd3
   } arb_state_t;

   localparam logic [1:0] POL_ROT_BYTE  = 2'b10;
   localparam logic [1:0] POL_ROT_BURST = 2'b11;

   // byte cap per burst: 1,2,3,4 then powers of two up to 64
   function automatic int unsigned burst_limit(input logic [2:0] code);
      if (code < 3'd4) return 32'(code) + 32'd1;
      return 32'd1 << (32'(code) - 32'd1);
   endfunction

   // idle clocks after a burst: 12,16,24 then 4<<code up to 512
   function automatic int unsigned gap_clocks(input logic [2:0] code);
      case (code)
         3'd0:    return 32'd12;
         3'd1:    return 32'd16;
         3'd2:    return 32'd24;
         default: return 32'd4 << code;
      endcase
   endfunction

endpackage

// File: rtl/dma_arb_rank.sv
// Picks the highest-ranked requester for a given rotation step.
module dma_arb_rank #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] req,
   input  logic [CH_W-1:0]   step,
   output logic [CH_W-1:0]   win,
   output logic              vld
);

   logic [CH_W-1:0] top_ch;

   assign top_ch = CH_W'(NUM_CH - 1) - step;
   assign vld    = |req;

   // walk from lowest rank to highest so the last hit wins
   always_comb begin
      win = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         logic [CH_W-1:0] cand;
         cand = top_ch - CH_W'(i);
         if (req[cand]) win = cand;
      end
   end

endmodule

// File: rtl/dma_arb_rot_ptr.sv
// Rotation step register; a constant zero when rotation is not built.
module dma_arb_rot_ptr #(
   parameter int NUM_CH = 8,
   parameter bit ROT_EN = 1'b1,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   output logic [CH_W-1:0] step
);

   generate
      if (ROT_EN) begin : g_rot
         logic [CH_W-1:0] step_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   step_q <= '0;
            else if (adv) step_q <= step_q + 1'b1;
         end
         assign step = step_q;
      end else begin : g_fixed
         logic unused_rot;
         assign unused_rot = adv ^ clk ^ rst_n;
         assign step = '0;
      end
   endgenerate

endmodule

// File: rtl/dma_arb_gap_timer.sv
// Down-counter for the idle gap between bursts.
module dma_arb_gap_timer #(
   parameter int GAP_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] load_val,
   output logic             done
);

   logic [GAP_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter bit ROT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic              byte_done,
   input  logic [1:0]        pol_mode,
   input  logic [2:0]        burst_code,
   input  logic [2:0]        gap_code,
   input  logic [1:0]        cpu_lvl,
   input  logic [1:0]        dma_lvl,
   input  logic              irq_pend,
   output logic [NUM_CH-1:0] grant,
   output logic              burst_act,
   output logic              dma_wins
);

   localparam int CH_W      = $clog2(NUM_CH);
   localparam int MAX_BURST = burst_limit(3'd7);
   localparam int BCNT_W    = $clog2(MAX_BURST + 1);
   localparam int MAX_GAP   = gap_clocks(3'd7);
   localparam int GAP_W     = $clog2(MAX_GAP);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_num_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
   endgenerate

   arb_state_t        state_q, state_d;
   logic [CH_W-1:0]   g_q, g_d;
   logic [BCNT_W-1:0] bcnt_q, bcnt_d, bcnt_inc, lim;
   logic [GAP_W-1:0]  gap_val;
   logic              allowed, rot_any, rot_byte, rot_burst, per_byte;
   logic [CH_W-1:0]   rot_step, step_now, step_next;
   logic [CH_W-1:0]   now_win, nxt_win;
   logic              now_vld, nxt_vld;
   logic              adv, burst_end, tmr_done;

   // ---------------- policy decode ----------------
   assign rot_any   = ROT_EN && pol_mode[1];
   assign rot_byte  = rot_any && (pol_mode == POL_ROT_BYTE);
   assign rot_burst = rot_any && (pol_mode == POL_ROT_BURST);
   assign per_byte  = !rot_burst;
   assign allowed   = (cpu_lvl <= dma_lvl);

   assign step_now  = rot_any  ? rot_step : '0;
   assign step_next = rot_byte ? rot_step + 1'b1 : step_now;

   assign lim      = BCNT_W'(burst_limit(burst_code));
   assign gap_val  = GAP_W'(gap_clocks(gap_code) - 32'd1);
   assign bcnt_inc = bcnt_q + 1'b1;

   // ---------------- ranking ----------------
   dma_arb_rank #(.NUM_CH(NUM_CH)) u_rank_now (
      .req  (req),
      .step (step_now),
      .win  (now_win),
      .vld  (now_vld)
   );

   dma_arb_rank #(.NUM_CH(NUM_CH)) u_rank_next (
      .req  (req),
      .step (step_next),
      .win  (nxt_win),
      .vld  (nxt_vld)
   );

   dma_arb_rot_ptr #(.NUM_CH(NUM_CH), .ROT_EN(ROT_EN)) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .step  (rot_step)
   );

   dma_arb_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (burst_end),
      .load_val (gap_val),
      .done     (tmr_done)
   );

   // ---------------- burst state machine ----------------
   always_comb begin
      state_d   = state_q;
      g_d       = g_q;
      bcnt_d    = bcnt_q;
      burst_end = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (allowed && now_vld) begin
               state_d = ST_BURST;
               g_d     = now_win;
               bcnt_d  = '0;
            end
         end
         ST_GAP: begin
            if (tmr_done) begin
               if (allowed && now_vld) begin
                  state_d = ST_BURST;
                  g_d     = now_win;
                  bcnt_d  = '0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_BURST: begin
            if (byte_done) bcnt_d = bcnt_inc;
            if (!allowed || !req[g_q]) begin
               burst_end = 1'b1;
            end else if (byte_done && bcnt_inc >= lim) begin
               burst_end = 1'b1;
            end else if (byte_done && per_byte && nxt_vld && nxt_win != g_q) begin
               state_d = ST_DEAD;
               g_d     = nxt_win;
            end
            if (burst_end) state_d = ST_GAP;
         end
         ST_DEAD: begin
            state_d = ST_BURST;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign adv = (rot_byte && state_q == ST_BURST && byte_done) ||
                (rot_burst && burst_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         g_q     <= '0;
         bcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         g_q     <= g_d;
         bcnt_q  <= bcnt_d;
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      grant = '0;
      if (state_q == ST_BURST) grant[g_q] = 1'b1;
   end

   assign burst_act = (state_q == ST_BURST) || (state_q == ST_DEAD);
   assign dma_wins  = irq_pend && allowed && (|req);

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] req,
   input logic              byte_done,
   input logic [2:0]        burst_code,
   input logic [2:0]        gap_code,
   input logic [1:0]        cpu_lvl,
   input logic [1:0]        dma_lvl,
   input logic              irq_pend,
   input logic [NUM_CH-1:0] grant,
   input logic              burst_act,
   input logic              dma_wins
);

   logic [10:0] low_cnt;
   logic        seen_burst;
   logic [7:0]  byte_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt    <= '0;
         seen_burst <= 1'b0;
         byte_cnt   <= '0;
      end else begin
         if (burst_act) begin
            low_cnt    <= '0;
            seen_burst <= 1'b1;
         end else if (low_cnt != 11'h7ff) begin
            low_cnt <= low_cnt + 1'b1;
         end
         if (!burst_act)                    byte_cnt <= '0;
         else if (byte_done && grant != '0) byte_cnt <= byte_cnt + 1'b1;
      end
   end

   a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r5_grant_implies_active: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> burst_act);

   a_r5_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && $past(grant) != '0) |-> grant == $past(grant));

   a_r8_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && (grant & req) == '0) |=> grant == '0);

   a_r9_start_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_act) |-> $past(cpu_lvl <= dma_lvl));

   a_r10_wins_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      dma_wins |-> (irq_pend && (|req)));

   a_r6_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      32'(byte_cnt) <= burst_limit(burst_code));

   a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(burst_act) && seen_burst) |-> 32'(low_cnt) >= gap_clocks(gap_code));

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .byte_done  (byte_done),
   .burst_code (burst_code),
   .gap_code   (gap_code),
   .cpu_lvl    (cpu_lvl),
   .dma_lvl    (dma_lvl),
   .irq_pend   (irq_pend),
   .grant      (grant),
   .burst_act  (burst_act),
   .dma_wins   (dma_wins)
);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic       byte_done = 1'b0;
   logic [1:0] pol_mode = 2'b00;
   logic [2:0] burst_code = 3'd7;
   logic [2:0] gap_code = 3'd0;
   logic [1:0] cpu_lvl = 2'd0;
   logic [1:0] dma_lvl = 2'd3;
   logic       irq_pend = 1'b0;
   logic [7:0] grant;
   logic       burst_act;
   logic       dma_wins;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_chan_arbiter i_dma_chan_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .byte_done(byte_done),
      .pol_mode(pol_mode), .burst_code(burst_code), .gap_code(gap_code),
      .cpu_lvl(cpu_lvl), .dma_lvl(dma_lvl), .irq_pend(irq_pend),
      .grant(grant), .burst_act(burst_act), .dma_wins(dma_wins)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; byte_done = 1'b0; irq_pend = 1'b0;
      cpu_lvl = 2'd0; dma_lvl = 2'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_byte();
      byte_done = 1'b1;
      @(negedge clk);
      byte_done = 1'b0;
   endtask

   task automatic count_low(output int n);
      n = 0;
      while (grant == '0 && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      chk("R11 reset grant", grant, 0);
      chk("R11 reset burst_act", burst_act, 0);
      chk("R11 reset dma_wins", dma_wins, 0);
   endtask

   task automatic t_fixed();
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      req = 8'h18;
      @(negedge clk);
      chk("R1 fixed 4 over 3", grant, 8'h10);
      pol_mode = 2'b01;
      do_reset();
      req = 8'h81;
      @(negedge clk);
      chk("R2 code 01 fixed, 7 over 0", grant, 8'h80);
      do_reset();
      req = 8'h01;
      @(negedge clk);
      chk("R1 channel 0 alone", grant, 8'h01);
   endtask

   task automatic t_preempt();
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      req = 8'h04;
      @(negedge clk);
      chk("R4 start ch2", grant, 8'h04);
      req = 8'h24;
      @(negedge clk);
      chk("R4 no takeover between bytes", grant, 8'h04);
      pulse_byte();
      chk("R5 dead clock grant", grant, 8'h00);
      chk("R5 dead clock burst_act", burst_act, 1);
      @(negedge clk);
      chk("R4 ch5 takes over", grant, 8'h20);
   endtask

   task automatic t_same();
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      req = 8'h08;
      @(negedge clk);
      byte_done = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R5 same channel no gap", grant, 8'h08);
      end
      byte_done = 1'b0;
   endtask

   task automatic t_rot_byte();
      pol_mode = 2'b10; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      req = 8'hC0;
      @(negedge clk);
      chk("R3 step0 ch7 first", grant, 8'h80);
      pulse_byte();
      chk("R5 rot dead clock", grant, 8'h00);
      @(negedge clk);
      chk("R3 step1 ch6", grant, 8'h40);
      pulse_byte();
      @(negedge clk);
      chk("R3 step2 ch7", grant, 8'h80);
   endtask

   task automatic t_rot_burst();
      int n;
      pol_mode = 2'b11; burst_code = 3'd1; gap_code = 3'd0;
      do_reset();
      req = 8'h08;
      @(negedge clk);
      chk("R2 rot burst start ch3", grant, 8'h08);
      req = 8'h28;
      pulse_byte();
      chk("R4 no takeover inside burst", grant, 8'h08);
      pulse_byte();
      chk("R6 cap 2 reached", burst_act, 0);
      count_low(n);
      chk("R7 gap code 0 is 12", n, 12);
      chk("R3 burst rotation picks ch5", grant, 8'h20);
   endtask

   task automatic t_burst_gap();
      int n;
      pol_mode = 2'b00; burst_code = 3'd4; gap_code = 3'd3;
      do_reset();
      req = 8'h02;
      @(negedge clk);
      for (int i = 0; i < 7; i++) pulse_byte();
      chk("R6 still granted after 7 of 8", grant, 8'h02);
      pulse_byte();
      chk("R6 cap 8 reached", grant, 8'h00);
      count_low(n);
      chk("R7 gap code 3 is 32", n, 32);
   endtask

   task automatic t_drop();
      int n;
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd7;
      do_reset();
      req = 8'h02;
      @(negedge clk);
      chk("R8 granted before drop", grant, 8'h02);
      req = 8'h00;
      @(negedge clk);
      chk("R8 drop ends burst", burst_act, 0);
      req = 8'h02;
      count_low(n);
      chk("R7 gap code 7 is 512", n, 512);
   endtask

   task automatic t_gate();
      int n;
      pol_mode = 2'b00; burst_code = 3'd7; gap_code = 3'd0;
      do_reset();
      dma_lvl = 2'd1; cpu_lvl = 2'd2; irq_pend = 1'b1; req = 8'h01;
      @(negedge clk);
      chk("R9 blocked above level", grant, 8'h00);
      chk("R10 no win while blocked", dma_wins, 0);
      repeat (3) @(negedge clk);
      chk("R9 still blocked", grant, 8'h00);
      cpu_lvl = 2'd1;
      #1;
      chk("R10 dma wins over irq", dma_wins, 1);
      @(negedge clk);
      chk("R9 equal level grants", grant, 8'h01);
      cpu_lvl = 2'd3;
      @(negedge clk);
      chk("R8 gate close ends burst", burst_act, 0);
      dma_lvl = 2'd3;
      count_low(n);
      chk("R9 level 3 runs at cpu 3 after gap", n, 12);
      req = 8'h00;
      #1;
      chk("R10 no win without request", dma_wins, 0);
   endtask

   initial begin
      t_reset();
      t_fixed();
      t_preempt();
      t_same();
      t_rot_byte();
      t_rot_burst();
      t_burst_gap();
      t_drop();
      t_gate();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule